// File: doc/BRIEF.md
# Per-Chip-Select Serial Clock and Frame Timing Generator

This block produces the serial clock, the chip-select lines and the bit-edge strobes for a serial-peripheral master that serves several slave devices. Each chip select owns a 32-bit mode word. The word sets the clock rest level, the clock phase, the bit order, the character length, the clock divider, the select lead and lag delays, and the pause between characters. A data shifter sits beside this block. It uses `sample_stb` and `launch_stb` to capture and present bits, and it reads `char_bits` and `msb_first` to frame each character.

A transaction begins with a one-cycle `xfer_start` while the block is idle. `xfer_sel` names the chip select and `xfer_chars_m1` gives the character count minus one. The block copies the selected mode word into an active copy at that moment. Writes made to the bank during the transaction therefore take effect only at the next start.

The controller is a five-state machine. IDLE leaves on an accepted start, to LEAD when the lead field is non-zero and to SHIFT otherwise. LEAD goes to SHIFT when its half-period count runs out. SHIFT toggles the clock on every half-period. After the last edge of a character, SHIFT goes to GAP when more characters remain and the gap field is non-zero, stays in SHIFT when the gap field is zero, and goes to LAG after the final character. GAP goes back to SHIFT when its count runs out. LAG goes to IDLE when its count runs out, and `done` pulses in that cycle.

Top module: `sclk_csgen`

## Requirements
- R1: After reset every mode word holds 0x0010_0008. This is active-low select, a gap of 1, zero delays, prescaler 0 and length field 0. With this value `sck` is 0, every `cs_line` bit is 1, `busy`, `done` and both strobes are 0, `char_bits` is 4 and `msb_first` is 0.
- R2: Bit 31 of the active word is the clock rest level. `sck` is at that level at the start, between characters and after the transaction, and it keeps that level until the next start.
- R3: Inside a character, consecutive `sck` edges are H system cycles apart. H = 2·(P+1)·(bit 28 ? 16 : 1), where P is bits 27:24.
- R4: Every `sck` edge comes with exactly one one-cycle strobe in the same cycle, and no strobe fires without an edge. Bit 30 clear makes the 1st, 3rd and later odd-numbered edges of a character sampling edges, so `sample_stb` fires on them and `launch_stb` fires on the others. Bit 30 set swaps the two.
- R5: Bits 19:16 hold the length minus one. A character has max(field+1, 4) bits, which is also the value of `char_bits`. Each character gets twice that many edges and that many sampling strobes.
- R6: `msb_first` equals bit 29 of the active word.
- R7: The first `sck` edge follows the select assertion by (2·L+1)·H cycles, where L is bits 15:12.
- R8: The select line returns to idle (2·G+1)·H cycles after the final edge, where G is bits 11:8. `done` pulses for one cycle in that same cycle, and `busy` is then 0.
- R9: The first edge of each later character follows the last edge of the previous one by (2·K+1)·H cycles, where K is bits 7:3.
- R10: Bit 20 set makes a select active low, and clear makes it active high. The selected line sits at its active level from the cycle after the start to the end of the transaction. Every other line sits at its own idle level, which equals its bit 20.
- R11: A transaction clocks exactly `xfer_chars_m1`+1 characters using the word of the chip select named at start.
- R12: A mode-word write made while busy does not change the running transaction and applies to the next one. A start made while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_sel | input | CSW | Chip select whose word is written |
| cfg_word | input | 32 | Mode word value |
| xfer_start | input | 1 | Start request, accepted only when idle |
| xfer_sel | input | CSW | Chip select of the requested transaction |
| xfer_chars_m1 | input | CHW | Character count minus one |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| sck | output | 1 | Serial clock |
| sample_stb | output | 1 | Pulse on a data-capture edge |
| launch_stb | output | 1 | Pulse on a data-shift edge |
| char_bits | output | 5 | Bits per character of the active word |
| msb_first | output | 1 | Bit order of the active word |
| cs_line | output | NCS | Chip-select lines at pin level |

## Verification
Directed transactions cover cases that the random stimulus rarely reaches. One is the reset word, where a length field of 0 must clamp to 4 bits. Another is the divide-by-16 stage with a high rest level and late phase, which separates H=64 from H=4. A third is a 16-bit character at the fastest rate, and the last is the slowest prescaler without the extra stage. Random words over all chip selects mix lead, lag and gap values from 0 to 3 with one to three characters. Any swap among the three delay formulas therefore shows up as a wrong interval at a specific edge. A transaction with a mid-flight word write and a competing start tells frozen-word behaviour apart from live reading. The following transaction confirms that the new word was then applied.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    localparam int PRESC_W  = 4;
    localparam int DIV16_SH = 4;

    typedef struct packed {
        logic               idle_hi;    // 31 clock rest level
        logic               late_ph;    // 30 first edge shifts
        logic               msb_first;  // 29 bit order
        logic               slow16;     // 28 extra divide by 16
        logic [PRESC_W-1:0] presc;      // 27:24
        logic [2:0]         rsv_hi;
        logic               sel_low;    // 20 select active low
        logic [3:0]         len_m1;     // 19:16
        logic [3:0]         lead;       // 15:12
        logic [3:0]         lag;        // 11:8
        logic [4:0]         gap;        // 7:3
        logic [2:0]         rsv_lo;
    } mode_t;

    localparam logic [31:0] MODE_RESET = 32'h0010_0008;

    typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_GAP, ST_LAG} frame_st_t;

    function automatic logic [4:0] bits_of(mode_t m);
        return (m.len_m1 < 4'd3) ? 5'd4 : ({1'b0, m.len_m1} + 5'd1);
    endfunction
endpackage

// File: rtl/sclk_modebank.sv
module sclk_modebank
    import sclk_pkg::*;
#(
    parameter int NCS = 4,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [CSW-1:0] wsel,
    input  logic [31:0]    wdata,
    input  logic [CSW-1:0] rsel,
    output mode_t          rmode,
    output logic [NCS-1:0] idle_lvl
);
    mode_t regs [NCS];

    for (genvar i = 0; i < NCS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= mode_t'(MODE_RESET);
            end else if (we && (wsel == CSW'(i))) begin
                regs[i] <= mode_t'(wdata);
            end
        end
        assign idle_lvl[i] = regs[i].sel_low;
    end

    always_comb begin
        rmode = mode_t'(MODE_RESET);
        for (int i = 0; i < NCS; i++) begin
            if (rsel == CSW'(i)) rmode = regs[i];
        end
    end
endmodule

// File: rtl/sclk_halftick.sv
module sclk_halftick
    import sclk_pkg::*;
#(
    localparam int CW = PRESC_W + DIV16_SH + 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  logic  run,
    input  mode_t tmode,
    output logic  tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] top;

    always_comb begin
        top = ((CW'(tmode.presc) + CW'(1)) << (tmode.slow16 ? (DIV16_SH + 1) : 1)) - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= top;
        end else if (run) begin
            cnt <= (cnt == '0) ? top : (cnt - 1'b1);
        end
    end

    assign tick = run && !restart && (cnt == '0);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart) |-> (cnt <= top));
endmodule

// File: rtl/sclk_framer.sv
module sclk_framer
    import sclk_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CHW = 8,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
    localparam int SEG_W = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CSW-1:0] start_sel,
    input  logic [CHW-1:0] chars_m1,
    input  mode_t          sel_mode,
    input  logic           tick,
    output logic           accept,
    output mode_t          tim_mode,
    output mode_t          act_mode,
    output logic [CSW-1:0] act_sel,
    output logic           busy,
    output logic           done,
    output logic           sck,
    output logic           sample_stb,
    output logic           launch_stb
);
    frame_st_t      st, nx;
    mode_t          lat;
    logic [SEG_W-1:0] seg;
    logic [5:0]     edge_n;
    logic [CHW-1:0] left;
    logic           sck_q, samp_q, lnch_q, done_q;
    logic [4:0]     bits_act;
    logic           last_edge;

    assign bits_act  = bits_of(lat);
    assign last_edge = (edge_n == (6'({bits_act, 1'b0}) - 6'd1));
    assign accept    = start && (st == ST_IDLE);
    assign tim_mode  = accept ? sel_mode : lat;

    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE:  if (start) nx = (sel_mode.lead != 4'd0) ? ST_LEAD : ST_SHIFT;
            ST_LEAD:  if (tick && seg == SEG_W'(1)) nx = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) begin
                          if (left == '0)              nx = ST_LAG;
                          else if (lat.gap != 5'd0)    nx = ST_GAP;
                          else                         nx = ST_SHIFT;
                      end
            ST_GAP:   if (tick && seg == SEG_W'(1)) nx = ST_SHIFT;
            ST_LAG:   if (tick && seg == SEG_W'(1)) nx = ST_IDLE;
            default:  nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat     <= mode_t'(MODE_RESET);
            act_sel <= '0;
            seg     <= '0;
            edge_n  <= '0;
            left    <= '0;
            sck_q   <= 1'b0;
            samp_q  <= 1'b0;
            lnch_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            samp_q <= 1'b0;
            lnch_q <= 1'b0;
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    lat     <= sel_mode;
                    act_sel <= start_sel;
                    left    <= chars_m1;
                    edge_n  <= '0;
                    sck_q   <= sel_mode.idle_hi;
                    seg     <= SEG_W'({sel_mode.lead, 1'b0});
                end
                ST_LEAD, ST_GAP: if (tick) seg <= seg - 1'b1;
                ST_LAG: if (tick) begin
                    seg    <= seg - 1'b1;
                    done_q <= (seg == SEG_W'(1));
                end
                ST_SHIFT: if (tick) begin
                    sck_q  <= ~sck_q;
                    samp_q <= (edge_n[0] == lat.late_ph);
                    lnch_q <= (edge_n[0] != lat.late_ph);
                    if (last_edge) begin
                        edge_n <= '0;
                        left   <= left - 1'b1;
                        seg    <= (left == '0) ? SEG_W'({lat.lag, 1'b1}) : SEG_W'({lat.gap, 1'b0});
                    end else begin
                        edge_n <= edge_n + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign act_mode   = lat;
    assign busy       = (st != ST_IDLE);
    assign done       = done_q;
    assign sck        = sck_q;
    assign sample_stb = samp_q;
    assign launch_stb = lnch_q;

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp_q && lnch_q));
    assert_strobe_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_q || lnch_q) |-> (sck_q != $past(sck_q)));
    assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (sck_q == lat.idle_hi));
    assert_mode_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_IDLE) && ($past(st) != ST_IDLE)) |-> $stable(lat));
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (st == ST_IDLE));
endmodule

// File: rtl/sclk_csgen.sv
module sclk_csgen
    import sclk_pkg::*;
#(
    parameter int NCS = 4,
    parameter int CHW = 8,
    localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CSW-1:0] cfg_sel,
    input  logic [31:0]    cfg_word,
    input  logic           xfer_start,
    input  logic [CSW-1:0] xfer_sel,
    input  logic [CHW-1:0] xfer_chars_m1,
    output logic           busy,
    output logic           done,
    output logic           sck,
    output logic           sample_stb,
    output logic           launch_stb,
    output logic [4:0]     char_bits,
    output logic           msb_first,
    output logic [NCS-1:0] cs_line
);
    mode_t          sel_mode, tim_mode, act_mode;
    logic [NCS-1:0] idle_lvl;
    logic [CSW-1:0] act_sel;
    logic           accept, tick;

    sclk_modebank #(.NCS(NCS)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wsel(cfg_sel), .wdata(cfg_word),
        .rsel(xfer_sel), .rmode(sel_mode), .idle_lvl(idle_lvl)
    );

    sclk_halftick u_tick (
        .clk(clk), .rst_n(rst_n), .restart(accept), .run(busy),
        .tmode(tim_mode), .tick(tick)
    );

    sclk_framer #(.NCS(NCS), .CHW(CHW)) u_frame (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .start_sel(xfer_sel),
        .chars_m1(xfer_chars_m1), .sel_mode(sel_mode), .tick(tick),
        .accept(accept), .tim_mode(tim_mode), .act_mode(act_mode), .act_sel(act_sel),
        .busy(busy), .done(done), .sck(sck), .sample_stb(sample_stb), .launch_stb(launch_stb)
    );

    assign char_bits = bits_of(act_mode);
    assign msb_first = act_mode.msb_first;

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_line[i] = (busy && act_sel == CSW'(i)) ? ~act_mode.sel_low : idle_lvl[i];
    end
endmodule

// File: tb/sim_sclk_csgen.sv
`timescale 1ns/1ps
module sim_sclk_csgen;
    localparam int NCS = 4;
    localparam int CHW = 8;
    localparam int CSW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [CSW-1:0] cfg_sel = '0;
    logic [31:0] cfg_word = '0;
    logic xfer_start = 1'b0;
    logic [CSW-1:0] xfer_sel = '0;
    logic [CHW-1:0] xfer_chars_m1 = '0;
    logic busy, done, sck, sample_stb, launch_stb, msb_first;
    logic [4:0] char_bits;
    logic [NCS-1:0] cs_line;

    int checks = 0;
    int errs = 0;
    int cyc = 0;
    logic [31:0] mdl [NCS];

    always #4 clk = ~clk;

    sclk_csgen #(.NCS(NCS), .CHW(CHW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_word(cfg_word),
        .xfer_start(xfer_start), .xfer_sel(xfer_sel), .xfer_chars_m1(xfer_chars_m1),
        .busy(busy), .done(done), .sck(sck), .sample_stb(sample_stb), .launch_stb(launch_stb),
        .char_bits(char_bits), .msb_first(msb_first), .cs_line(cs_line)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit cpol, bit cpha, bit msb, bit d16, int pm, bit csl,
                                       int len, int lead, int lag, int gap);
        return {cpol, cpha, msb, d16, 4'(pm), 3'b0, csl, 4'(len), 4'(lead), 4'(lag), 5'(gap), 3'b0};
    endfunction

    task automatic wr(input int cs, input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = CSW'(cs); cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
        mdl[cs] = w;
    endtask

    task automatic run_xfer(input int cs, input int nch, input bit poke, input logic [31:0] pw);
        logic [31:0] w;
        int h, bits, lead, lag, gap, idx, last, e, p, expi, nsamp;
        int nb_lead, nb_gap, nb_rate, nb_ph, nb_idle, nb_cs;
        logic prev;
        bit exps;
        w = mdl[cs];
        h = 2 * (int'(w[27:24]) + 1) * (w[28] ? 16 : 1);
        bits = (w[19:16] < 3) ? 4 : int'(w[19:16]) + 1;
        lead = int'(w[15:12]); lag = int'(w[11:8]); gap = int'(w[7:3]);
        @(negedge clk);
        xfer_start = 1'b1; xfer_sel = CSW'(cs); xfer_chars_m1 = CHW'(nch - 1);
        @(negedge clk);
        xfer_start = 1'b0;
        chk(busy === 1'b1 && cs_line[cs] === ~w[20], "R10", "select asserted at start", int'(cs_line[cs]), int'(~w[20]));
        chk(char_bits === 5'(bits), "R5", "char_bits", int'(char_bits), bits);
        chk(msb_first === w[29], "R6", "msb_first", int'(msb_first), int'(w[29]));
        idx = 0; last = 0; e = 0; nsamp = 0; prev = sck;
        nb_lead = 0; nb_gap = 0; nb_rate = 0; nb_ph = 0; nb_idle = 0; nb_cs = 0;
        while (idx < 40000) begin
            if (poke && idx == 3) begin
                cfg_we = 1'b1; cfg_sel = CSW'(cs); cfg_word = pw;
                xfer_start = 1'b1; xfer_sel = CSW'((cs + 1) % NCS);
            end
            if (poke && idx == 4) begin
                cfg_we = 1'b0; xfer_start = 1'b0; mdl[cs] = pw;
            end
            @(negedge clk);
            idx++;
            if (sck !== prev) begin
                p = e % (2 * bits);
                expi = (e == 0) ? (2 * lead + 1) * h : ((p == 0) ? (2 * gap + 1) * h : h);
                if (idx - last != expi) begin
                    if (e == 0) nb_lead++;
                    else if (p == 0) nb_gap++;
                    else nb_rate++;
                end
                exps = ((p % 2) == 0) ^ w[30];
                if (sample_stb !== exps || launch_stb !== !exps) nb_ph++;
                if (sample_stb === 1'b1) nsamp++;
                e++; last = idx; prev = sck;
            end else begin
                if (sample_stb === 1'b1 || launch_stb === 1'b1) nb_ph++;
                if ((e % (2 * bits)) == 0 && sck !== w[31]) nb_idle++;
            end
            if (done === 1'b1) break;
            for (int i = 0; i < NCS; i++) begin
                if (i != cs && cs_line[i] !== mdl[i][20]) nb_cs++;
            end
            if (cs_line[cs] !== ~w[20]) nb_cs++;
        end
        chk(done === 1'b1, "R8", "transaction completes", int'(done), 1);
        chk(idx - last == (2 * lag + 1) * h, "R8", "lag after last edge", idx - last, (2 * lag + 1) * h);
        chk(cs_line[cs] === w[20] && busy === 1'b0, "R10", "select released at done", int'(cs_line[cs]), int'(w[20]));
        chk(nb_lead == 0, "R7", "lead interval errors", nb_lead, 0);
        chk(nb_gap == 0, "R9", "gap interval errors", nb_gap, 0);
        chk(nb_rate == 0, "R3", "half-period errors", nb_rate, 0);
        chk(nb_ph == 0, "R4", "strobe/edge mismatches", nb_ph, 0);
        chk(nb_idle == 0, "R2", "rest level errors", nb_idle, 0);
        chk(nb_cs == 0, "R10", "select level errors", nb_cs, 0);
        chk(e == 2 * bits * nch, "R11", "edge total", e, 2 * bits * nch);
        chk(nsamp == bits * nch, "R5", "sample strobes", nsamp, bits * nch);
        @(negedge clk);
        chk(done === 1'b0 && sck === w[31], "R2", "rest level after end", int'(sck), int'(w[31]));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] wa, wb;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCS; i++) mdl[i] = 32'h0010_0008;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sck === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "sck/busy/done at reset", int'(sck), 0);
        chk(cs_line === 4'hF, "R1", "select lines at reset", int'(cs_line), 15);
        chk(sample_stb === 1'b0 && launch_stb === 1'b0, "R1", "strobes at reset", int'(sample_stb), 0);
        chk(char_bits === 5'd4 && msb_first === 1'b0, "R1", "decoded fields at reset", int'(char_bits), 4);

        // reset word: length field 0 clamps to 4 bits (R5), gap 1 between chars (R9)
        run_xfer(2, 2, 1'b0, 32'h0);
        // divide-by-16, rest high, late phase, active-high select
        wr(1, mk(1, 1, 1, 1, 1, 0, 3, 1, 1, 0));
        run_xfer(1, 2, 1'b0, 32'h0);
        // 16-bit character at fastest rate
        wr(3, mk(0, 0, 1, 0, 0, 1, 15, 0, 0, 2));
        run_xfer(3, 1, 1'b0, 32'h0);
        // slowest prescaler without the extra stage
        wr(2, mk(0, 1, 0, 0, 15, 1, 4, 0, 2, 0));
        run_xfer(2, 1, 1'b0, 32'h0);

        // R12: write during busy and a competing start
        wa = mk(1, 0, 0, 0, 1, 1, 5, 1, 0, 1);
        wb = mk(0, 1, 1, 0, 0, 1, 9, 0, 1, 0);
        wr(0, wa);
        run_xfer(0, 2, 1'b1, wb);
        @(negedge clk);
        chk(busy === 1'b0 && cs_line[1] === mdl[1][20], "R12", "start during busy ignored", int'(busy), 0);
        run_xfer(0, 1, 1'b0, 32'h0);

        // constrained random
        for (int k = 0; k < 20; k++) begin
            int cs;
            cs = int'($urandom % NCS);
            wr(cs, mk(1'($urandom), 1'($urandom), 1'($urandom), 0, int'($urandom % 4), 1'($urandom),
                      int'($urandom % 16), int'($urandom % 4), int'($urandom % 4), int'($urandom % 4)));
            run_xfer(cs, 1 + int'($urandom % 3), 1'b0, 32'h0);
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule